// File: doc/BRIEF.md
# Compressed Bitstream Buffer with Data-Request Flow Control

This block holds an incoming compressed audio bitstream between a serial front end and a decoder. Bytes from the front end are written into a 2048-byte store. The decoder pulls them out in arrival order through a ready/valid read port. Write and read run on one clock.

A data-request output tells the host whether it may send more data. The request drops once the buffer holds more than 16128 bits (2016 bytes) and comes back once it holds less. When the fill sits exactly on that level, the request keeps its previous value. The 256-bit gap between this level and full means a host that sees the request high can always send another 32 bytes.

In stream-receiver mode the block also drives a small sample-rate correction. The correction rises when data arrives faster than it is consumed and falls when data arrives more slowly. Playback speed then follows the incoming data rate rather than a fixed clock. A write into a full store and a read from an empty store each raise a flag that stays set until reset.

Top module: `bsbuf_top`

## Requirements
- R1: Bytes leave the read port in the order they were accepted. `rd_valid` is high exactly when the buffer holds at least one byte. A cycle with both an accepted write and an accepted read leaves the fill unchanged.
- R2: The buffer accepts up to 2048 bytes before it is full.
- R3: A write while the buffer holds 2048 bytes is dropped and never appears on the read port. From the next cycle `overflow` is 1, and it stays 1 until reset.
- R4: Raising `rd_ready` while the buffer is empty removes nothing. From the next cycle `underflow` is 1, and it stays 1 until reset.
- R5: `dreq` is 0 in any cycle in which the buffer holds more than 2016 bytes (16128 bits).
- R6: `dreq` is 1 whenever the buffer holds fewer than 2016 bytes. At exactly 2016 bytes it keeps its value from the previous cycle.
- R7: Starting from any cycle in which `dreq` is 1, at least 32 more writes are accepted without setting `overflow`.
- R8: With `stream_mode` at 1, `rate_trim` follows the current fill. It is 2'b01 (+1) when the fill is above 1152 bytes, 2'b11 (-1) when the fill is below 896 bytes, and 2'b00 (0) from 896 to 1152 inclusive. It takes a new value on the same clock edge as the fill it reflects.
- R9: One cycle after `stream_mode` has been 0, `rate_trim` is 2'b00, whatever the fill.
- R10: While `rst_n` is low at a clock edge, the buffer empties. After that edge `dreq` is 1, `rd_valid` is 0, `overflow` is 0, `underflow` is 0 and `rate_trim` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by the write and read sides |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | A byte is offered on wr_data this cycle |
| wr_data | input | 8 | Incoming bitstream byte |
| rd_ready | input | 1 | The decoder takes the byte on rd_data this cycle |
| rd_valid | output | 1 | rd_data holds the oldest stored byte |
| rd_data | output | 8 | Oldest stored byte |
| stream_mode | input | 1 | 1 enables the sample-rate correction output |
| dreq | output | 1 | Host may send more data |
| rate_trim | output | 2 | Signed correction: 01 = +1, 11 = -1, 00 = 0 |
| overflow | output | 1 | Sticky: a write arrived while full |
| underflow | output | 1 | Sticky: a read was requested while empty |

## Verification
The hardest states to reach are the cycles in which the fill sits exactly on the 2016-byte request level. The request must keep its old value there, and which value it holds depends on the direction of arrival. The bench first climbs to 2016 bytes with writes alone, so the request must stay high. It then crosses to 2017 and backs down to 2016 with single reads, so the request must stay low, and only at 2015 must it come back. The same fill is then topped up to the 2048-byte limit, a dropped write is added, and the whole store is drained, so the scoreboard can confirm that the dropped byte never comes out.

// File: rtl/bsbuf_pkg.sv
// Shared types for the bitstream buffer.
// Assumes two's complement encoding for the rate correction code.
package bsbuf_pkg;
    typedef enum logic [1:0] {
        TRIM_ZERO = 2'b00,
        TRIM_UP   = 2'b01,
        TRIM_DOWN = 2'b11
    } trim_t;
endpackage

// File: rtl/bsbuf_store.sv
// Byte store with write and read pointers.
// Assumes DEPTH is a power of two. The fill counter decides whether a push or
// pop may happen, so this module never checks for full or empty itself.
module bsbuf_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata
);
    localparam int ADDR_W = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] wr_ptr;
    logic [ADDR_W-1:0] rd_ptr;

    // Move the pointers on accepted pushes and pops; both wrap naturally.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + ADDR_W'(1);
            if (pop)  rd_ptr <= rd_ptr + ADDR_W'(1);
        end
    end

    // Write the byte into the slot under the write pointer.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    // Present the oldest byte.
    assign rdata = mem[rd_ptr];
endmodule

// File: rtl/bsbuf_fill.sv
// Fill counter: admits pushes and pops, holds the byte count and sets the
// sticky error flags. Also exports the next count so that the flow-control
// outputs can register from it and line up with the count itself.
module bsbuf_fill #(
    parameter int DEPTH = 2048
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_valid,
    input  logic                       rd_ready,
    output logic                       push,
    output logic                       pop,
    output logic [$clog2(DEPTH+1)-1:0] fill_q,
    output logic [$clog2(DEPTH+1)-1:0] fill_d,
    output logic                       overflow,
    output logic                       underflow
);
    localparam int FILL_W = $clog2(DEPTH + 1);
    localparam logic [FILL_W-1:0] FULL_L = FILL_W'(DEPTH);

    logic is_full;
    logic is_empty;

    // Decode full and empty from the current count.
    assign is_full  = (fill_q == FULL_L);
    assign is_empty = (fill_q == '0);

    // Admit a write only when there is room and a read only when there is data.
    assign push = wr_valid && !is_full;
    assign pop  = rd_ready && !is_empty;

    // Work out the count after this cycle.
    always_comb begin
        unique case ({push, pop})
            2'b10:   fill_d = fill_q + FILL_W'(1);
            2'b01:   fill_d = fill_q - FILL_W'(1);
            default: fill_d = fill_q;
        endcase
    end

    // Register the count and the sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q    <= '0;
            overflow  <= 1'b0;
            underflow <= 1'b0;
        end else begin
            fill_q <= fill_d;
            if (wr_valid && is_full)  overflow  <= 1'b1;
            if (rd_ready && is_empty) underflow <= 1'b1;
        end
    end
endmodule

// File: rtl/bsbuf_dreq.sv
// Data-request generator with a one-level hold band.
// The request drops above LEVEL and rises below LEVEL; at LEVEL it keeps its
// value. It registers from the next fill, so it changes on the same edge as
// the count.
module bsbuf_dreq #(
    parameter int FILL_W = 12,
    parameter int LEVEL  = 2016
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FILL_W-1:0] fill_d,
    output logic              dreq
);
    localparam logic [FILL_W-1:0] LEVEL_L = FILL_W'(LEVEL);

    // Update the request from the next fill, holding it at the level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dreq <= 1'b1;
        end else if (fill_d > LEVEL_L) begin
            dreq <= 1'b0;
        end else if (fill_d < LEVEL_L) begin
            dreq <= 1'b1;
        end
    end
endmodule

// File: rtl/bsbuf_trim.sv
// Stream-mode rate correction: compares the next fill against two watermarks
// and registers a signed step of +1, 0 or -1. Outside stream mode the step
// is always 0.
module bsbuf_trim
    import bsbuf_pkg::*;
#(
    parameter int FILL_W = 12,
    parameter int LO_WM  = 896,
    parameter int HI_WM  = 1152
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stream_mode,
    input  logic [FILL_W-1:0] fill_d,
    output logic [1:0]        rate_trim
);
    localparam logic [FILL_W-1:0] LO_L = FILL_W'(LO_WM);
    localparam logic [FILL_W-1:0] HI_L = FILL_W'(HI_WM);

    trim_t step_d;
    trim_t step_q;

    // Pick the correction step from the watermarks.
    always_comb begin
        if (!stream_mode)       step_d = TRIM_ZERO;
        else if (fill_d > HI_L) step_d = TRIM_UP;
        else if (fill_d < LO_L) step_d = TRIM_DOWN;
        else                    step_d = TRIM_ZERO;
    end

    // Register the step.
    always_ff @(posedge clk) begin
        if (!rst_n) step_q <= TRIM_ZERO;
        else        step_q <= step_d;
    end

    assign rate_trim = step_q;
endmodule

// File: rtl/bsbuf_top.sv
// Bitstream buffer top: byte store, fill counter, data-request generator and
// stream-mode rate correction. Write and read share clk; reset is synchronous
// and active low. Assumes DEPTH is a power of two and MARGIN_BITS is a whole
// number of bytes.
module bsbuf_top #(
    parameter int DATA_W      = 8,
    parameter int DEPTH       = 2048,
    parameter int MARGIN_BITS = 256,
    parameter int WM_SPAN     = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              stream_mode,
    output logic              dreq,
    output logic [1:0]        rate_trim,
    output logic              overflow,
    output logic              underflow
);
    localparam int FILL_W   = $clog2(DEPTH + 1);
    localparam int MARGIN   = MARGIN_BITS / DATA_W;
    localparam int DREQ_LVL = DEPTH - MARGIN;
    localparam int TRIM_HI  = DEPTH / 2 + WM_SPAN;
    localparam int TRIM_LO  = DEPTH / 2 - WM_SPAN;

    logic              push;
    logic              pop;
    logic [FILL_W-1:0] fill_q;
    logic [FILL_W-1:0] fill_d;

    bsbuf_fill #(.DEPTH(DEPTH)) u_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .rd_ready  (rd_ready),
        .push      (push),
        .pop       (pop),
        .fill_q    (fill_q),
        .fill_d    (fill_d),
        .overflow  (overflow),
        .underflow (underflow)
    );

    bsbuf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .wdata (wr_data),
        .pop   (pop),
        .rdata (rd_data)
    );

    bsbuf_dreq #(.FILL_W(FILL_W), .LEVEL(DREQ_LVL)) u_dreq (
        .clk    (clk),
        .rst_n  (rst_n),
        .fill_d (fill_d),
        .dreq   (dreq)
    );

    bsbuf_trim #(.FILL_W(FILL_W), .LO_WM(TRIM_LO), .HI_WM(TRIM_HI)) u_trim (
        .clk         (clk),
        .rst_n       (rst_n),
        .stream_mode (stream_mode),
        .fill_d      (fill_d),
        .rate_trim   (rate_trim)
    );

    // Data is on offer whenever the count is non-zero.
    assign rd_valid = (fill_q != '0);
endmodule

// File: rtl/bsbuf_chk.sv
// Property checker for bsbuf_top, attached by the bind at the end of the file.
// It observes the ports and the registered fill count.
module bsbuf_chk #(
    parameter int DEPTH    = 2048,
    parameter int DREQ_LVL = 2016
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_valid,
    input logic                       rd_ready,
    input logic                       rd_valid,
    input logic                       stream_mode,
    input logic                       dreq,
    input logic [1:0]                 rate_trim,
    input logic                       overflow,
    input logic                       underflow,
    input logic [$clog2(DEPTH+1)-1:0] fill
);
    localparam int FILL_W = $clog2(DEPTH + 1);
    localparam logic [FILL_W-1:0] CAP_L = FILL_W'(DEPTH);
    localparam logic [FILL_W-1:0] LVL_L = FILL_W'(DREQ_LVL);

    // R1: valid tracks a non-empty store.
    p_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid == (fill != '0));

    // R2: the count never passes capacity.
    p_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CAP_L);

    // R3: a write into a full store raises the overflow flag.
    p_ovf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && fill == CAP_L) |=> overflow);

    // R3: overflow is sticky.
    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R4: a read request on an empty store raises underflow and it sticks.
    p_udf_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ready && !rd_valid) |=> underflow);

    p_udf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);

    // R5: request is low above the level.
    p_dreq_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fill > LVL_L) |-> !dreq);

    // R6: request is high below the level and holds at the level.
    p_dreq_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fill < LVL_L) |-> dreq);

    p_dreq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == LVL_L) |-> (dreq == $past(dreq)));

    // R8: the correction code is never the unused value.
    p_trim_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rate_trim != 2'b10);

    // R9: normal mode forces a zero correction on the next cycle.
    p_trim_normal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !stream_mode |=> (rate_trim == 2'b00));
endmodule

bind bsbuf_top bsbuf_chk #(.DEPTH(DEPTH), .DREQ_LVL(DREQ_LVL)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .rd_ready    (rd_ready),
    .rd_valid    (rd_valid),
    .stream_mode (stream_mode),
    .dreq        (dreq),
    .rate_trim   (rate_trim),
    .overflow    (overflow),
    .underflow   (underflow),
    .fill        (fill_q)
);

// File: tb/bsbuf_top_tb.sv
// Scoreboard bench for bsbuf_top: driver tasks push accepted bytes into a
// queue, a monitor pops and compares on every read handshake.
module bsbuf_top_tb;
    localparam int DEPTH = 2048;
    localparam int LVL   = 2016;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_ready = 1'b0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       stream_mode = 1'b0;
    logic       dreq;
    logic [1:0] rate_trim;
    logic       overflow;
    logic       underflow;

    int         n_chk = 0;
    int         n_fail = 0;
    int         mfill = 0;
    logic [7:0] sb [$];
    logic [7:0] seed = 8'h5a;
    bit         done = 1'b0;

    bsbuf_top u_dut (
        .clk (clk), .rst_n (rst_n), .wr_valid (wr_valid), .wr_data (wr_data),
        .rd_ready (rd_ready), .rd_valid (rd_valid), .rd_data (rd_data),
        .stream_mode (stream_mode), .dreq (dreq), .rate_trim (rate_trim),
        .overflow (overflow), .underflow (underflow)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] next_byte();
        seed = {seed[6:0], seed[7] ^ seed[5] ^ seed[4] ^ seed[3]};
        return seed;
    endfunction

    // Monitor: a handshake seen at the falling edge completes at the next rise.
    always @(negedge clk) begin
        if (rst_n && rd_valid && rd_ready) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R1 unexpected byte", int'(rd_data), -1);
            end else begin
                chk(rd_data == sb[0], "R1 read order", int'(rd_data), int'(sb[0]));
                void'(sb.pop_front());
            end
        end
    end

    // Drive one cycle with optional write and read, updating the model.
    task automatic step(input bit w, input bit r);
        logic [7:0] b;
        b = next_byte();
        wr_valid = w;
        wr_data  = b;
        rd_ready = r;
        @(posedge clk);
        if (w && mfill < DEPTH) sb.push_back(b);
        if (w && r && mfill > 0 && mfill < DEPTH) mfill = mfill;
        else if (w && mfill < DEPTH) mfill++;
        else if (r && mfill > 0) mfill--;
        #1;
        wr_valid = 1'b0;
        rd_ready = 1'b0;
    endtask

    task automatic wr_n(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0);
    endtask

    task automatic rd_n(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        sb.delete();
        mfill = 0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            finish_run();
        end
    end

    initial begin
        stream_mode = 1'b1;
        @(posedge clk);
        #1;
        do_reset();
        // R10: reset state
        chk(dreq == 1'b1, "R10 dreq", int'(dreq), 1);
        chk(rd_valid == 1'b0, "R10 rd_valid", int'(rd_valid), 0);
        chk(overflow == 1'b0, "R10 overflow", int'(overflow), 0);
        chk(underflow == 1'b0, "R10 underflow", int'(underflow), 0);
        chk(rate_trim == 2'b00, "R10 rate_trim", int'(rate_trim), 0);

        // R8: watermarks in stream mode
        wr_n(895);
        chk(rate_trim == 2'b11, "R8 trim at 895", int'(rate_trim), 3);
        wr_n(1);
        chk(rate_trim == 2'b00, "R8 trim at 896", int'(rate_trim), 0);
        wr_n(256);
        chk(rate_trim == 2'b00, "R8 trim at 1152", int'(rate_trim), 0);
        wr_n(1);
        chk(rate_trim == 2'b01, "R8 trim at 1153", int'(rate_trim), 1);
        // R9: normal mode zeroes the correction
        stream_mode = 1'b0;
        step(1'b0, 1'b0);
        chk(rate_trim == 2'b00, "R9 trim in normal mode", int'(rate_trim), 0);
        rd_n(1153);
        chk(rd_valid == 1'b0, "R1 empty after drain", int'(rd_valid), 0);

        // R1: interleaved writes and reads keep order and fill
        wr_n(3);
        for (int i = 0; i < 10; i++) step(1'b1, 1'b1);
        rd_n(3);
        chk(rd_valid == 1'b0, "R1 fill unchanged by paired cycles", int'(rd_valid), 0);
        chk(sb.size() == 0, "R1 scoreboard empty", sb.size(), 0);

        // R5 / R6: request level and hold band
        wr_n(LVL);
        chk(dreq == 1'b1, "R6 hold high at 2016", int'(dreq), 1);
        wr_n(1);
        chk(dreq == 1'b0, "R5 low at 2017", int'(dreq), 0);
        rd_n(1);
        chk(dreq == 1'b0, "R6 hold low at 2016", int'(dreq), 0);
        rd_n(1);
        chk(dreq == 1'b1, "R6 high at 2015", int'(dreq), 1);

        // R7 / R2 / R3: headroom, capacity, dropped write
        wr_n(32);
        chk(overflow == 1'b0, "R7 32 bytes after request", int'(overflow), 0);
        wr_n(1);
        chk(overflow == 1'b0, "R2 2048th byte accepted", int'(overflow), 0);
        chk(dreq == 1'b0, "R5 low when full", int'(dreq), 0);
        wr_n(1);
        chk(overflow == 1'b1, "R3 overflow set", int'(overflow), 1);
        stream_mode = 1'b1;
        rd_n(DEPTH);
        chk(rd_valid == 1'b0, "R3 dropped byte absent", int'(rd_valid), 0);
        chk(sb.size() == 0, "R2 all bytes read", sb.size(), 0);
        chk(overflow == 1'b1, "R3 overflow sticky", int'(overflow), 1);
        chk(rate_trim == 2'b11, "R8 trim when empty", int'(rate_trim), 3);

        // R4: read from empty
        rd_n(1);
        chk(underflow == 1'b1, "R4 underflow set", int'(underflow), 1);
        chk(rd_valid == 1'b0, "R4 still empty", int'(rd_valid), 0);
        wr_n(1);
        chk(underflow == 1'b1, "R4 underflow sticky", int'(underflow), 1);

        // R10: reset mid-run empties and clears
        wr_n(4);
        do_reset();
        chk(rd_valid == 1'b0, "R10 empty after reset", int'(rd_valid), 0);
        chk(dreq == 1'b1, "R10 dreq after reset", int'(dreq), 1);
        chk(overflow == 1'b0, "R10 overflow cleared", int'(overflow), 0);
        chk(underflow == 1'b0, "R10 underflow cleared", int'(underflow), 0);
        chk(rate_trim == 2'b00, "R10 trim cleared", int'(rate_trim), 0);
        wr_n(2);
        rd_n(2);
        chk(sb.size() == 0, "R1 order after reset", sb.size(), 0);

        done = 1'b1;
        finish_run();
    end
endmodule